// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits in the receive path of a D-channel HDLC controller. Flag detection and bit destuffing happen upstream, and each frame arrives as a byte stream in which the first and last octets are marked. The filter screens every frame by its leading address octets. The first octet carries the service access point identifier (SAPI) and the second carries the terminal endpoint identifier (TEI). The filter passes the stream through unchanged. On the closing octet it states whether the frame is wanted, so that a downstream buffer writer can commit the frame or roll it back.

Each address field has a bank of programmable match keys and a broadcast value. A per-field activity mask selects which keys take part, and the mask also decides whether the broadcast value takes part. A match depth setting chooses how many fields must match: none, the first only, or both. With matching switched off, every frame is accepted. When a frame is accepted through a real address match, a sticky status flag is set, and that flag can drive an interrupt.

Both stream sides use valid/ready. The filter adds no storage on the data path. `m_valid` follows `s_valid` and `s_ready` follows `m_ready`, so back-pressure from the consumer reaches the producer in the same cycle. A beat moves only when valid and ready are both high. A stalled beat must be held steady by the producer, and it does not advance the filter's octet position.

Top module: `addr_filt`

## Requirements
- R1: Every input beat appears on the output in the same cycle with data and markers unaltered, including the address octets. `m_valid` equals `s_valid` and `s_ready` equals `m_ready`.
- R2: Configuration is written through the register port. Address 0 holds the control register: bit0 enables matching, bits 2:1 set the depth (0 = none, 1 = first field, 2 or 3 = both fields) and bit3 enables the interrupt. Address 1 is the SAPI mask and address 2 is the TEI mask: bits N-1:0 activate keys and bit7 activates the broadcast value. Writing 1 to bit0 of address 3 clears the status flag. SAPI keys sit at addresses 4..4+N-1 and TEI keys at 4+N..4+2N-1, both right-justified. The SAPI broadcast value is at 4+2N and the TEI broadcast value at 5+2N. After reset, matching is off and all masks are zero.
- R3: When matching is disabled, or the depth is none, `m_accept` is 1 on every closing beat and the status flag is not set.
- R4: At depth first-field, bits 7:2 of the first octet are compared and bits 1:0 are ignored. The frame is accepted if the field equals an active key, or equals the broadcast value while broadcast is active.
- R5: At depth both-fields, the first field must match as in R4, and bits 7:1 of the second octet must match an active TEI key or the active TEI broadcast value. Bit 0 of the second octet is ignored.
- R6: A key whose mask bit is 0 never causes acceptance, even when it equals the field.
- R7: The broadcast values reset to 63 for SAPI and 127 for TEI, and both can be reprogrammed.
- R8: A frame that ends before all octets required by the depth are present is discarded.
- R9: The status flag is set in the cycle after an accepted closing beat transfers with matching enabled and a non-zero depth. It stays set until cleared, and `irq` equals the flag ANDed with the interrupt enable.
- R10: `m_accept` is 0 on every beat that is not a closing beat.
- R11: A stalled beat does not advance the octet position, so decisions are unaffected by back-pressure.
- R12: A beat with the start marker always counts as octet 0, even if the previous frame was not closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address |
| cfg_wdata | input | 8 | Register write data |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_data | input | 8 | Input octet |
| s_sof | input | 1 | First octet of frame |
| s_eof | input | 1 | Last octet of frame |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Consumer ready |
| m_data | output | 8 | Output octet |
| m_sof | output | 1 | First octet of frame |
| m_eof | output | 1 | Last octet of frame |
| m_accept | output | 1 | Keep-frame decision, only on closing beat |
| match_sts | output | 1 | Sticky address-match status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the filter with the default of four keys per field, so every key slot, both broadcast registers and mask bit 7 can be reached. Random frame bytes are drawn mostly from the programmed keys and the broadcast values, with random low-order bits, so that hits, misses and ignored-bit cases all occur often. The bench also varies frame length between one and five octets and drops `m_ready` at random. This exposes short frames, stalls and restarts without a closing beat across all depth settings.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  localparam int OCT_W  = 8;
  localparam int SAPI_W = 6;
  localparam int TEI_W  = 7;
  localparam int SAPI_LO = 2;
  localparam int TEI_LO  = 1;

  localparam int REG_CTRL  = 0;
  localparam int REG_SMASK = 1;
  localparam int REG_TMASK = 2;
  localparam int REG_CLEAR = 3;
  localparam int REG_KEYS  = 4;
  localparam int BC_BIT    = 7;

  typedef enum logic [1:0] {
    DEP_NONE   = 2'd0,
    DEP_FIRST  = 2'd1,
    DEP_BOTH   = 2'd2,
    DEP_BOTH_X = 2'd3
  } depth_e;
endpackage

// File: rtl/addr_filt_cfg.sv
module addr_filt_cfg
  import addr_filt_pkg::*;
#(
  parameter int N_KEYS = 4,
  parameter int CFG_AW = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [CFG_AW-1:0]             addr,
  input  logic [OCT_W-1:0]              wdata,
  output logic                          en,
  output depth_e                        depth,
  output logic                          irq_en,
  output logic [N_KEYS-1:0]             s_act,
  output logic                          s_bc_on,
  output logic [N_KEYS-1:0]             t_act,
  output logic                          t_bc_on,
  output logic [N_KEYS-1:0][SAPI_W-1:0] s_key,
  output logic [N_KEYS-1:0][TEI_W-1:0]  t_key,
  output logic [SAPI_W-1:0]             s_bc,
  output logic [TEI_W-1:0]              t_bc,
  output logic                          clr
);
  localparam int S_BASE = REG_KEYS;
  localparam int T_BASE = REG_KEYS + N_KEYS;
  localparam int SBC_A  = REG_KEYS + 2 * N_KEYS;
  localparam int TBC_A  = SBC_A + 1;

  wire unused_wbits = ^wdata;

  function automatic logic hit_addr(input logic [CFG_AW-1:0] a, input int tgt);
    return we && (a == CFG_AW'(tgt));
  endfunction

  assign clr = hit_addr(addr, REG_CLEAR) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      depth   <= DEP_NONE;
      irq_en  <= 1'b0;
      s_act   <= '0;
      s_bc_on <= 1'b0;
      t_act   <= '0;
      t_bc_on <= 1'b0;
      s_bc    <= '1;
      t_bc    <= '1;
    end else begin
      if (hit_addr(addr, REG_CTRL)) begin
        en     <= wdata[0];
        depth  <= depth_e'(wdata[2:1]);
        irq_en <= wdata[3];
      end
      if (hit_addr(addr, REG_SMASK)) begin
        s_act   <= wdata[N_KEYS-1:0];
        s_bc_on <= wdata[BC_BIT];
      end
      if (hit_addr(addr, REG_TMASK)) begin
        t_act   <= wdata[N_KEYS-1:0];
        t_bc_on <= wdata[BC_BIT];
      end
      if (hit_addr(addr, SBC_A)) s_bc <= wdata[SAPI_W-1:0];
      if (hit_addr(addr, TBC_A)) t_bc <= wdata[TEI_W-1:0];
    end
  end

  for (genvar g = 0; g < N_KEYS; g++) begin : g_keys
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_key[g] <= '0;
        t_key[g] <= '0;
      end else begin
        if (hit_addr(addr, S_BASE + g)) s_key[g] <= wdata[SAPI_W-1:0];
        if (hit_addr(addr, T_BASE + g)) t_key[g] <= wdata[TEI_W-1:0];
      end
    end
  end
endmodule

// File: rtl/addr_filt_cmp.sv
module addr_filt_cmp #(
  parameter int N_KEYS = 4,
  parameter int KW     = 6
) (
  input  logic [KW-1:0]             fld,
  input  logic [N_KEYS-1:0][KW-1:0] keys,
  input  logic [N_KEYS-1:0]         act,
  input  logic [KW-1:0]             bc,
  input  logic                      bc_on,
  output logic                      hit
);
  logic [N_KEYS-1:0] key_hit;

  for (genvar g = 0; g < N_KEYS; g++) begin : g_cmp
    assign key_hit[g] = act[g] && (fld == keys[g]);
  end

  assign hit = (|key_hit) || (bc_on && (fld == bc));
endmodule

// File: rtl/addr_filt_ctl.sv
module addr_filt_ctl
  import addr_filt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire,
  input  logic   sof,
  input  logic   eof,
  input  logic   hit1_now,
  input  logic   hit2_now,
  input  logic   en,
  input  depth_e depth,
  input  logic   clr,
  output logic   keep,
  output logic   sts
);
  logic [1:0] pos_q, pos_cur;
  logic       hit1_q, hit2_q;
  logic       h1, h2;
  logic       filtering;

  assign pos_cur   = sof ? 2'd0 : pos_q;
  assign h1        = (pos_cur == 2'd0) ? hit1_now : hit1_q;
  assign h2        = (pos_cur == 2'd1) ? hit2_now :
                     (pos_cur == 2'd2) ? hit2_q : 1'b0;
  assign filtering = en && (depth != DEP_NONE);

  always_comb begin
    if (!filtering)              keep = 1'b1;
    else if (depth == DEP_FIRST) keep = h1;
    else                         keep = h1 && h2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= 2'd0;
      hit1_q <= 1'b0;
      hit2_q <= 1'b0;
      sts    <= 1'b0;
    end else begin
      if (fire) begin
        if (eof)                  pos_q <= 2'd0;
        else if (pos_cur != 2'd2) pos_q <= pos_cur + 2'd1;
        else                      pos_q <= 2'd2;
        if (pos_cur == 2'd0) hit1_q <= hit1_now;
        if (pos_cur == 2'd1) hit2_q <= hit2_now;
      end
      if (fire && eof && filtering && keep) sts <= 1'b1;
      else if (clr)                         sts <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_filt.sv
module addr_filt
  import addr_filt_pkg::*;
#(
  parameter int N_KEYS = 4,
  parameter int CFG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_sof,
  input  logic              s_eof,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_data,
  output logic              m_sof,
  output logic              m_eof,
  output logic              m_accept,
  output logic              match_sts,
  output logic              irq
);
  logic                          en, irq_en, s_bc_on, t_bc_on, clr;
  depth_e                        depth;
  logic [N_KEYS-1:0]             s_act, t_act;
  logic [N_KEYS-1:0][SAPI_W-1:0] s_key;
  logic [N_KEYS-1:0][TEI_W-1:0]  t_key;
  logic [SAPI_W-1:0]             s_bc;
  logic [TEI_W-1:0]              t_bc;
  logic                          hit1, hit2, keep, fire;

  addr_filt_cfg #(.N_KEYS(N_KEYS), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(en), .depth(depth), .irq_en(irq_en),
    .s_act(s_act), .s_bc_on(s_bc_on), .t_act(t_act), .t_bc_on(t_bc_on),
    .s_key(s_key), .t_key(t_key), .s_bc(s_bc), .t_bc(t_bc), .clr(clr)
  );

  addr_filt_cmp #(.N_KEYS(N_KEYS), .KW(SAPI_W)) u_sapi (
    .fld(s_data[OCT_W-1:SAPI_LO]), .keys(s_key), .act(s_act),
    .bc(s_bc), .bc_on(s_bc_on), .hit(hit1)
  );

  addr_filt_cmp #(.N_KEYS(N_KEYS), .KW(TEI_W)) u_tei (
    .fld(s_data[OCT_W-1:TEI_LO]), .keys(t_key), .act(t_act),
    .bc(t_bc), .bc_on(t_bc_on), .hit(hit2)
  );

  assign fire = s_valid && m_ready;

  addr_filt_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sof(s_sof), .eof(s_eof),
    .hit1_now(hit1), .hit2_now(hit2), .en(en), .depth(depth), .clr(clr),
    .keep(keep), .sts(match_sts)
  );

  assign m_valid  = s_valid;
  assign s_ready  = m_ready;
  assign m_data   = s_data;
  assign m_sof    = s_sof;
  assign m_eof    = s_eof;
  assign m_accept = s_valid && s_eof && keep;
  assign irq      = match_sts && irq_en;
endmodule

// File: rtl/addr_filt_chk.sv
module addr_filt_chk #(
  parameter int CFG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic              s_valid,
  input logic              s_sof,
  input logic              s_eof,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_eof,
  input logic              m_accept,
  input logic              match_sts,
  input logic              irq,
  input logic              en,
  input logic [1:0]        depth
);
  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_addr == CFG_AW'(3)) && cfg_wdata[0];

  AST_OPEN_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en || depth == 2'd0) && m_valid && m_eof) |-> m_accept); // R3
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && depth[1] && s_valid && s_sof && s_eof) |-> !m_accept); // R8
  AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_accept && en && depth != 2'd0) |=> match_sts); // R9
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (match_sts && !clr_wr) |=> match_sts); // R9
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> match_sts); // R9
  AST_EOF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    m_accept |-> (m_valid && m_eof)); // R10
endmodule

bind addr_filt addr_filt_chk #(.CFG_AW(CFG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_sof(s_sof), .s_eof(s_eof),
  .m_valid(m_valid), .m_ready(m_ready), .m_eof(m_eof), .m_accept(m_accept),
  .match_sts(match_sts), .irq(irq), .en(en), .depth(depth)
);

// File: tb/addr_filt_test.sv
module addr_filt_test;
  localparam int N = 4;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic s_valid = 0, s_sof = 0, s_eof = 0, m_ready = 1;
  logic [7:0] s_data = '0;
  logic s_ready, m_valid, m_sof, m_eof, m_accept, match_sts, irq;
  logic [7:0] m_data;

  addr_filt #(.N_KEYS(N), .CFG_AW(AW)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit en_s = 0, ie_s = 0, sbon = 0, tbon = 0, sts_exp = 0;
  int dep_s = 0;
  logic [N-1:0] sact = '0, tact = '0;
  logic [5:0] skey [N];
  logic [6:0] tkey [N];
  logic [5:0] sbc = 6'd63;
  logic [6:0] tbc = 7'd127;
  logic [7:0] fb [8];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_ctrl(bit e, int d, bit ie);
    en_s = e; dep_s = d; ie_s = ie;
    wr(0, {4'd0, ie, 2'(d), e});
  endtask
  task automatic set_smask(logic [N-1:0] m, bit b);
    sact = m; sbon = b; wr(1, {b, 3'd0, m});
  endtask
  task automatic set_tmask(logic [N-1:0] m, bit b);
    tact = m; tbon = b; wr(2, {b, 3'd0, m});
  endtask
  task automatic clear_sts();
    sts_exp = 0; wr(3, 1);
  endtask

  function automatic bit sapi_hit(logic [7:0] b);
    bit h = sbon && (b[7:2] == sbc);
    for (int i = 0; i < N; i++) if (sact[i] && b[7:2] == skey[i]) h = 1;
    return h;
  endfunction
  function automatic bit tei_hit(logic [7:0] b);
    bit h = tbon && (b[7:1] == tbc);
    for (int i = 0; i < N; i++) if (tact[i] && b[7:1] == tkey[i]) h = 1;
    return h;
  endfunction
  function automatic bit exp_keep(int len);
    if (!en_s || dep_s == 0) return 1;
    if (dep_s == 1) return sapi_hit(fb[0]);
    return (len >= 2) && sapi_hit(fb[0]) && tei_hit(fb[1]);
  endfunction

  function automatic logic [7:0] gen_sapi();
    int r = $urandom % 6;
    logic [5:0] v = (r < 4) ? skey[r] : (r == 4) ? sbc : 6'($urandom);
    return {v, 2'($urandom)};
  endfunction
  function automatic logic [7:0] gen_tei();
    int r = $urandom % 6;
    logic [6:0] v = (r < 4) ? tkey[r] : (r == 4) ? tbc : 7'($urandom);
    return {v, 1'($urandom)};
  endfunction

  // Drive one beat and hold it until it transfers; m_ready varies randomly.
  task automatic beat(logic [7:0] d, bit sof, bit eof, bit stall_ok, output bit acc);
    bit done = 0;
    @(negedge clk);
    s_valid = 1; s_data = d; s_sof = sof; s_eof = eof;
    while (!done) begin
      m_ready = stall_ok ? ($urandom % 4 != 0) : 1'b1;
      #1;
      check(m_valid && m_data == d && m_sof == sof && m_eof == eof && s_ready == m_ready,
            "R1 passthrough", int'(m_data), int'(d));
      if (!eof) check(m_accept == 0, "R10 accept off non-eof", m_accept, 0);
      acc = m_accept;
      @(posedge clk);
      if (m_ready) done = 1;
      else @(negedge clk);
    end
  endtask

  task automatic frame(int len, bit stall_ok, string tag);
    bit acc = 0;
    bit ek = exp_keep(len);
    for (int i = 0; i < len; i++) beat(fb[i], i == 0, i == len - 1, stall_ok, acc);
    if (en_s && dep_s != 0 && ek) sts_exp = 1;
    check(acc == ek, tag, acc, ek);
    @(negedge clk);
    s_valid = 0; s_sof = 0; s_eof = 0;
    #1;
    check(match_sts == sts_exp, "R9 status", match_sts, sts_exp);
    check(irq == (sts_exp && ie_s), "R9 irq", irq, sts_exp && ie_s);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired");
    summary();
  end

  initial begin
    bit acc;
    process::self().srandom(32'd7391);
    for (int i = 0; i < N; i++) begin skey[i] = '0; tkey[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(match_sts == 0 && irq == 0 && m_accept == 0, "R2 reset outputs", match_sts, 0);

    // R2 reset: matching off, every frame kept
    fb[0] = 8'h10; fb[1] = 8'h22;
    frame(2, 0, "R2 reset pass-all");

    // R7 default broadcast SAPI 63, first-field depth
    set_ctrl(1, 1, 1);
    set_smask('0, 1);
    fb[0] = 8'hFD; fb[1] = 8'h00;
    frame(2, 0, "R7 sapi broadcast default");
    clear_sts();
    fb[0] = 8'h04;
    frame(2, 0, "R4 miss discarded");

    // R7 default TEI broadcast 127 at depth both
    set_ctrl(1, 2, 1);
    set_tmask('0, 1);
    fb[0] = 8'hFC; fb[1] = 8'hFE;
    frame(3, 0, "R7 tei broadcast default");
    clear_sts();

    // program keys
    for (int i = 0; i < N; i++) begin
      skey[i] = 6'(5 * i + 3); wr(4 + i, skey[i]);
      tkey[i] = 7'(9 * i + 1); wr(4 + N + i, tkey[i]);
    end

    // R6 inactive key ignored
    set_ctrl(1, 1, 0);
    set_smask(4'b1101, 0);
    fb[0] = {skey[1], 2'b11};
    frame(2, 0, "R6 inactive key");
    fb[0] = {skey[2], 2'b10};
    frame(2, 0, "R4 active key ignores low bits");

    // R8 short frame at depth both
    set_ctrl(1, 3, 0);
    set_tmask(4'b1111, 0);
    fb[0] = {skey[0], 2'b00};
    frame(1, 0, "R8 short frame");

    // R12 restart without closing beat
    beat(8'h00, 1, 0, 0, acc);
    beat(8'h01, 0, 0, 0, acc);
    fb[0] = {skey[3], 2'b01}; fb[1] = {tkey[2], 1'b1};
    frame(2, 0, "R12 restart at sof");

    // R7 reprogram broadcast values
    sbc = 6'd12; wr(4 + 2 * N, sbc);
    tbc = 7'd40; wr(5 + 2 * N, tbc);
    set_smask('0, 1); set_tmask('0, 1);
    fb[0] = {sbc, 2'b10}; fb[1] = {tbc, 1'b0};
    frame(2, 0, "R7 reprogrammed broadcast");
    clear_sts();

    // R3 enabled with depth none
    set_ctrl(1, 0, 1);
    fb[0] = 8'h33; fb[1] = 8'h44;
    frame(2, 0, "R3 depth none");

    // random phase with stalls
    for (int f = 0; f < 400; f++) begin
      if (f % 25 == 0) begin
        set_ctrl(($urandom % 5) != 0, $urandom % 4, 1'($urandom));
        set_smask(N'($urandom), 1'($urandom));
        set_tmask(N'($urandom), 1'($urandom));
        if ($urandom % 2) clear_sts();
      end
      fb[0] = gen_sapi(); fb[1] = gen_tei();
      for (int i = 2; i < 8; i++) fb[i] = 8'($urandom);
      frame(1 + $urandom % 5, 1, "R4 R5 R11 random accept");
    end

    summary();
  end
endmodule